// File: doc/BRIEF.md
# Remote Ring Buffer Accessor

This block gives a local client byte-level access to two circular buffers that live in another processor's memory. It cannot touch that memory directly. Every access goes through a shared bus: the block raises an acquire request, waits for the grant, performs single-byte reads and writes, then drops the request and waits for the grant to fall before it moves on. Each buffer keeps three control bytes just below its data area: the size mask (buffer length minus one) at base-3, the producer (write) index at base-2 and the consumer (read) index at base-1. The data bytes start at base. The base addresses of the two buffers are parameters.

The block keeps a local shadow of each buffer's indices and mask. An init command fills the shadows from remote memory. Status commands (not-empty, not-full) compare one freshly read remote index with the shadow. Get and put commands first poll the status and release the bus between polls, so the remote processor can make progress. Only then do they move one byte and advance the matching index under the mask.

Commands enter on a valid/ready stream. The block accepts one command when both `cmd_valid` and `cmd_ready` are high, and it holds `cmd_ready` low until the response has been taken. Results leave on a valid/ready stream. `rsp_valid` stays high with stable `rsp_flag` and `rsp_byte` until `rsp_ready` is seen high at a clock edge, so a slow consumer back-pressures the block without losing a result. The memory port uses its own valid/ready pair.

Top module: `ring_accessor`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bus_req`, `mem_valid` and `rsp_valid` are 0.
- R2: A memory access is issued only while both `bus_req` and `bus_gnt` are high. After its last access a command drops `bus_req` and waits until `bus_gnt` is low before it acquires again or responds. The count of grants per command is exactly the number of bracketed phases that the command needs.
- R3: Command code 0 (init) uses one acquisition to read six bytes in this order: buffer 0 at base-1, base-2, base-3, then buffer 1 at base-1, base-2, base-3. It loads them as the consumer index, producer index and mask shadows. It responds with flag 0 and byte 0.
- R4: Command code 1 (not-empty) reads base-2 of the selected buffer in one acquisition. It responds with flag 1 when that byte differs from the shadow consumer index.
- R5: Command code 2 (not-full) reads base-1 of the selected buffer in one acquisition. It responds with flag 1 when ((shadow producer index + 1) AND mask) differs from that byte.
- R6: Command code 3 (get) polls base-2 with one acquisition per poll until the buffer is non-empty. In a further acquisition it reads base + consumer index and writes the advanced consumer index to base-1. It responds with flag 1 and the fetched byte.
- R7: Command code 4 (put) polls base-1 with one acquisition per poll until the buffer is not full. In a further acquisition it writes `cmd_byte` at base + producer index and writes the advanced producer index to base-2. It responds with flag 1.
- R8: Indices advance as (index + 1) AND mask, so an index equal to the mask wraps to 0.
- R9: `cmd_ready` is low from the cycle after acceptance until the response is taken. `rsp_valid`, `rsp_flag` and `rsp_byte` hold steady while `rsp_ready` is low.
- R10: `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready` is seen high. Read data is taken in that cycle.
- R11: `cmd_sel` (0 or 1) picks the buffer. A command touches only that buffer's addresses and shadows.
- R12: Command codes 5 to 7 cause no bus activity and respond with flag 0 and byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted on this edge |
| cmd_op | input | 3 | Command code (0 init, 1 not-empty, 2 not-full, 3 get, 4 put) |
| cmd_sel | input | 1 | Buffer select |
| cmd_byte | input | 8 | Byte to put |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_flag | output | 1 | Status result |
| rsp_byte | output | 8 | Fetched byte (get), else 0 |
| bus_req | output | 1 | Bus acquire request |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory access completes |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Remote byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |

## Verification
The bench targets the empty and full polls that must repeat while the remote side is still working. A design that held the bus across polls, or that never polled again, would either stall the remote update and hang, or return stale data. Index wrap is driven with a consumer and a producer index equal to the mask; a design that dropped the mask would write an index past the buffer end. Response back-pressure and a full init sequence with mixed masks are also checked. So is the not-full case where the next index equals the remote consumer: a design that compared the wrong shadow or the wrong control byte would flip that flag.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int NUM_FIFO = 2;
  localparam int IDX_W    = 8;
  localparam int SEL_W    = $clog2(NUM_FIFO);
  localparam int INIT_N   = 3 * NUM_FIFO;
  localparam int STEP_W   = $clog2(INIT_N);

  localparam logic [2:0] OP_INIT   = 3'd0;
  localparam logic [2:0] OP_NEMPTY = 3'd1;
  localparam logic [2:0] OP_NFULL  = 3'd2;
  localparam logic [2:0] OP_GETC   = 3'd3;
  localparam logic [2:0] OP_PUTC   = 3'd4;

  typedef enum logic [1:0] {K_DATA, K_PROD, K_CONS, K_MASK} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_MEM, S_REL, S_RSP} state_e;
endpackage

// File: rtl/ring_shadow.sv
module ring_shadow
  import ring_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_fifo,
  input  kind_e                         wr_kind,
  input  logic [IDX_W-1:0]              wr_val,
  output logic [NUM_FIFO-1:0][IDX_W-1:0] cons_idx,
  output logic [NUM_FIFO-1:0][IDX_W-1:0] prod_idx,
  output logic [NUM_FIFO-1:0][IDX_W-1:0] size_mask
);
  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
    logic hit;
    assign hit = wr_en && (wr_fifo == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cons_idx[g]  <= '0;
        prod_idx[g]  <= '0;
        size_mask[g] <= '0;
      end else if (hit) begin
        case (wr_kind)
          K_CONS:  cons_idx[g]  <= wr_val;
          K_PROD:  prod_idx[g]  <= wr_val;
          K_MASK:  size_mask[g] <= wr_val;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ring_step.sv
module ring_step
  import ring_pkg::*;
(
  input  logic [2:0]       op,
  input  logic             poll,
  input  logic [STEP_W-1:0] step,
  input  logic [SEL_W-1:0] sel,
  input  logic [IDX_W-1:0] cur_cons,
  input  logic [IDX_W-1:0] cur_prod,
  input  logic [IDX_W-1:0] nxt_cons,
  input  logic [IDX_W-1:0] nxt_prod,
  input  logic [7:0]       put_byte,
  output kind_e            kind,
  output logic [SEL_W-1:0] fifo,
  output logic [IDX_W-1:0] idx,
  output logic             we,
  output logic [7:0]       wdata,
  output logic             last
);
  always_comb begin
    kind  = K_CONS;
    fifo  = sel;
    idx   = '0;
    we    = 1'b0;
    wdata = '0;
    last  = 1'b1;
    case (op)
      OP_INIT: begin
        fifo = SEL_W'(step / STEP_W'(3));
        case (step % STEP_W'(3))
          STEP_W'(0): kind = K_CONS;
          STEP_W'(1): kind = K_PROD;
          default:    kind = K_MASK;
        endcase
        last = (step == STEP_W'(INIT_N - 1));
      end
      OP_NEMPTY: kind = K_PROD;
      OP_NFULL:  kind = K_CONS;
      OP_GETC: begin
        if (poll) kind = K_PROD;
        else if (step == '0) begin
          kind = K_DATA;
          idx  = cur_cons;
          last = 1'b0;
        end else begin
          kind  = K_CONS;
          we    = 1'b1;
          wdata = nxt_cons;
        end
      end
      OP_PUTC: begin
        if (poll) kind = K_CONS;
        else if (step == '0) begin
          kind  = K_DATA;
          idx   = cur_prod;
          we    = 1'b1;
          wdata = put_byte;
          last  = 1'b0;
        end else begin
          kind  = K_PROD;
          we    = 1'b1;
          wdata = nxt_prod;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ring_addr.sv
module ring_addr
  import ring_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_A = 'h0100,
  parameter logic [ADDR_W-1:0] BASE_B = 'h0200
) (
  input  logic [SEL_W-1:0]  fifo,
  input  kind_e             kind,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base;
  assign base = (fifo != '0) ? BASE_B : BASE_A;

  always_comb begin
    case (kind)
      K_DATA:  addr = base + ADDR_W'(idx);
      K_PROD:  addr = base - ADDR_W'(2);
      K_CONS:  addr = base - ADDR_W'(1);
      default: addr = base - ADDR_W'(3);
    endcase
  end
endmodule

// File: rtl/ring_accessor.sv
module ring_accessor
  import ring_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE0  = 'h0100,
  parameter logic [ADDR_W-1:0] BASE1  = 'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_sel,
  input  logic [7:0]        cmd_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_flag,
  output logic [7:0]        rsp_byte,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  state_e            st;
  logic [2:0]        op_q;
  logic [SEL_W-1:0]  sel_q;
  logic [7:0]        put_q, byte_q;
  logic              flag_q, poll_q;
  logic [STEP_W-1:0] step_q;

  logic [NUM_FIFO-1:0][IDX_W-1:0] cons_idx, prod_idx, size_mask;
  logic [IDX_W-1:0] cur_cons, cur_prod, cur_mask, nxt_cons, nxt_prod;

  kind_e            d_kind;
  logic [SEL_W-1:0] d_fifo;
  logic [IDX_W-1:0] d_idx;
  logic             d_we, d_last;
  logic [7:0]       d_wdata;

  logic             hs, sh_en, ne_hit, nf_hit, legal;
  logic [IDX_W-1:0] sh_val;

  assign cur_cons = cons_idx[sel_q];
  assign cur_prod = prod_idx[sel_q];
  assign cur_mask = size_mask[sel_q];
  assign nxt_cons = (cur_cons + IDX_W'(1)) & cur_mask;
  assign nxt_prod = (cur_prod + IDX_W'(1)) & cur_mask;

  ring_step u_step (
    .op(op_q), .poll(poll_q), .step(step_q), .sel(sel_q),
    .cur_cons(cur_cons), .cur_prod(cur_prod),
    .nxt_cons(nxt_cons), .nxt_prod(nxt_prod), .put_byte(put_q),
    .kind(d_kind), .fifo(d_fifo), .idx(d_idx), .we(d_we),
    .wdata(d_wdata), .last(d_last)
  );

  ring_addr #(.ADDR_W(ADDR_W), .BASE_A(BASE0), .BASE_B(BASE1)) u_addr (
    .fifo(d_fifo), .kind(d_kind), .idx(d_idx), .addr(mem_addr)
  );

  assign hs     = (st == S_MEM) && mem_ready;
  assign ne_hit = (mem_rdata != cur_cons);
  assign nf_hit = (nxt_prod != mem_rdata);
  assign legal  = (cmd_op <= OP_PUTC);
  assign sh_en  = hs && ((op_q == OP_INIT) ||
                  (((op_q == OP_GETC) || (op_q == OP_PUTC)) && !poll_q && (step_q != '0)));
  assign sh_val = (op_q == OP_INIT) ? mem_rdata : d_wdata;

  ring_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(sh_en), .wr_fifo(d_fifo),
    .wr_kind(d_kind), .wr_val(sh_val),
    .cons_idx(cons_idx), .prod_idx(prod_idx), .size_mask(size_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      sel_q  <= '0;
      put_q  <= '0;
      byte_q <= '0;
      flag_q <= 1'b0;
      poll_q <= 1'b0;
      step_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          sel_q  <= cmd_sel;
          put_q  <= cmd_byte;
          byte_q <= '0;
          flag_q <= 1'b0;
          step_q <= '0;
          poll_q <= (cmd_op == OP_GETC) || (cmd_op == OP_PUTC);
          st     <= legal ? S_ACQ : S_RSP;
        end
        S_ACQ: if (bus_gnt) st <= S_MEM;
        S_MEM: if (mem_ready) begin
          case (op_q)
            OP_NEMPTY: flag_q <= ne_hit;
            OP_NFULL:  flag_q <= nf_hit;
            OP_GETC: begin
              if (poll_q) flag_q <= ne_hit;
              else if (step_q == '0) byte_q <= mem_rdata;
            end
            OP_PUTC: if (poll_q) flag_q <= nf_hit;
            default: ;
          endcase
          if (d_last) st <= S_REL;
          else step_q <= step_q + STEP_W'(1);
        end
        S_REL: if (!bus_gnt) begin
          if (poll_q) begin
            step_q <= '0;
            if (flag_q) poll_q <= 1'b0;
            st <= S_ACQ;
          end else begin
            st <= S_RSP;
          end
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign rsp_flag  = flag_q;
  assign rsp_byte  = byte_q;
  assign bus_req   = (st == S_ACQ) || (st == S_MEM);
  assign mem_valid = (st == S_MEM);
  assign mem_we    = d_we;
  assign mem_wdata = d_wdata;

  assert_mem_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (bus_req && bus_gnt));

  assert_rsp_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_gnt);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_flag) && $stable(rsp_byte)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

// File: tb/ring_accessor_test.sv
module ring_accessor_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_sel = 1'b0, rsp_ready = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_byte = '0;
  logic cmd_ready, rsp_valid, rsp_flag, bus_req, mem_valid, mem_we;
  logic [7:0] rsp_byte, mem_wdata;
  logic [15:0] mem_addr;
  logic bus_gnt = 1'b0, mem_ready = 1'b0;
  logic [7:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_accessor uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_flag(rsp_flag),
    .rsp_byte(rsp_byte), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct packed { logic we; logic [15:0] addr; logic [7:0] data; } acc_t;
  acc_t exp_q[$];
  logic [7:0] mem [int];
  int n_chk = 0, n_fail = 0, acq_cnt = 0, rel_cnt = 0;
  int pend_at = -1;
  logic [15:0] pend_addr = '0;
  logic [7:0]  pend_val = '0;
  string cur_tag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mrd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  task automatic expect_acc(input logic we, input logic [15:0] a, input logic [7:0] d);
    acc_t e;
    e.we = we; e.addr = a; e.data = d;
    exp_q.push_back(e);
  endtask

  // bus owner and memory model, plus scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 1'b0; mem_ready = 1'b0;
    end else begin
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, cur_tag, "unexpected access", {15'd0, mem_we, mem_addr}, 32'h0);
        else begin
          acc_t e;
          e = exp_q.pop_front();
          check(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
                cur_tag, "access", {7'd0, mem_we, mem_addr, mem_wdata},
                {7'd0, e.we, e.addr, e.data});
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        else mem_rdata = mrd(mem_addr);
        mem_ready = 1'b1;
      end
      if (bus_req && !bus_gnt) begin
        bus_gnt = 1'b1; acq_cnt++;
      end else if (!bus_req && bus_gnt) begin
        bus_gnt = 1'b0; rel_cnt++;
        if (rel_cnt == pend_at) begin
          mem[int'(pend_addr)] = pend_val;
          pend_at = -1;
        end
      end
    end
  end

  task automatic run_cmd(input logic [2:0] op, input logic sel, input logic [7:0] b,
                         input int hold, input int e_acq, input logic e_flag,
                         input logic [7:0] e_byte, input string tag);
    int a0;
    cur_tag = tag;
    a0 = acq_cnt;
    @(negedge clk);
    cmd_op = op; cmd_sel = sel; cmd_byte = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R9", "ready after accept", cmd_ready, 0);
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_byte == e_byte && rsp_flag == e_flag, "R9",
            "held response", {rsp_valid, rsp_flag, rsp_byte}, {1'b1, e_flag, e_byte});
    end
    check(rsp_flag == e_flag, tag, "flag", rsp_flag, e_flag);
    check(rsp_byte == e_byte, tag, "byte", rsp_byte, e_byte);
    check(acq_cnt - a0 == e_acq, "R2", "acquisitions", acq_cnt - a0, e_acq);
    check(exp_q.size() == 0, tag, "accesses left", exp_q.size(), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(cmd_ready == 1'b1, "R9", "ready after response", cmd_ready, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    mem[16'h00FD] = 8'h07; mem[16'h00FE] = 8'h00; mem[16'h00FF] = 8'h00;
    mem[16'h01FD] = 8'h03; mem[16'h01FE] = 8'h02; mem[16'h01FF] = 8'h01;
    mem[16'h0201] = 8'hA1; mem[16'h0202] = 8'hB2; mem[16'h0203] = 8'hC3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !bus_req && !mem_valid && !rsp_valid, "R1", "reset state",
          {cmd_ready, bus_req, mem_valid, rsp_valid}, 4'b1000);

    // R3 init
    expect_acc(0, 16'h00FF, 0); expect_acc(0, 16'h00FE, 0); expect_acc(0, 16'h00FD, 0);
    expect_acc(0, 16'h01FF, 0); expect_acc(0, 16'h01FE, 0); expect_acc(0, 16'h01FD, 0);
    run_cmd(3'd0, 0, 0, 0, 1, 0, 8'h00, "R3");
    // R4 not-empty, both buffers (R11)
    expect_acc(0, 16'h00FE, 0);
    run_cmd(3'd1, 0, 0, 0, 1, 0, 8'h00, "R4");
    expect_acc(0, 16'h01FE, 0);
    run_cmd(3'd1, 1, 0, 0, 1, 1, 8'h00, "R11");
    // R5 not-full
    expect_acc(0, 16'h00FF, 0);
    run_cmd(3'd2, 0, 0, 0, 1, 1, 8'h00, "R5");
    // R6 get with back-pressure
    expect_acc(0, 16'h01FE, 0); expect_acc(0, 16'h0201, 0); expect_acc(1, 16'h01FF, 8'h02);
    run_cmd(3'd3, 1, 0, 3, 2, 1, 8'hA1, "R6");
    // R6 get on empty buffer, remote fills after two polls
    pend_at = rel_cnt + 2; pend_addr = 16'h01FE; pend_val = 8'h03;
    expect_acc(0, 16'h01FE, 0); expect_acc(0, 16'h01FE, 0); expect_acc(0, 16'h01FE, 0);
    expect_acc(0, 16'h0202, 0); expect_acc(1, 16'h01FF, 8'h03);
    run_cmd(3'd3, 1, 0, 0, 4, 1, 8'hB2, "R6");
    // R8 consumer wrap 3 -> 0
    mem[16'h01FE] = 8'h00;
    expect_acc(0, 16'h01FE, 0); expect_acc(0, 16'h0203, 0); expect_acc(1, 16'h01FF, 8'h00);
    run_cmd(3'd3, 1, 0, 0, 2, 1, 8'hC3, "R8");
    // R7 put
    expect_acc(0, 16'h00FF, 0); expect_acc(1, 16'h0100, 8'h55); expect_acc(1, 16'h00FE, 8'h01);
    run_cmd(3'd4, 0, 8'h55, 0, 2, 1, 8'h00, "R7");
    expect_acc(0, 16'h01FF, 0); expect_acc(1, 16'h0202, 8'h66); expect_acc(1, 16'h01FE, 8'h03);
    run_cmd(3'd4, 1, 8'h66, 0, 2, 1, 8'h00, "R7");
    // R7/R8 put on full buffer, remote drains after one poll, producer wraps
    pend_at = rel_cnt + 1; pend_addr = 16'h01FF; pend_val = 8'h01;
    expect_acc(0, 16'h01FF, 0); expect_acc(0, 16'h01FF, 0);
    expect_acc(1, 16'h0203, 8'h77); expect_acc(1, 16'h01FE, 8'h00);
    run_cmd(3'd4, 1, 8'h77, 0, 3, 1, 8'h00, "R8");
    check(mrd(16'h0203) == 8'h77, "R7", "stored byte", mrd(16'h0203), 8'h77);
    // R5 full detection after wrap
    expect_acc(0, 16'h01FF, 0);
    run_cmd(3'd2, 1, 0, 0, 1, 0, 8'h00, "R5");
    // R4 sees put on buffer 0
    expect_acc(0, 16'h00FE, 0);
    run_cmd(3'd1, 0, 0, 0, 1, 1, 8'h00, "R4");
    // R12 unused code
    run_cmd(3'd5, 0, 0, 0, 0, 0, 8'h00, "R12");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule